// File: doc/BRIEF.md
# Single-Channel DMA Element Mover

This block is the data-moving core of one DMA channel. It keeps four 32-bit registers: a source address, a destination address, a control word and a configuration word. Software, or a descriptor fetcher, loads them through a small register write port. Their current values are always visible on output buses. While the channel is enabled and not halted, the block moves one element at a time. Each element is a single read from the source followed by a single write to the destination, both on a one-access-at-a-time memory master port.

Each element may start only when the peripheral request lines allow it. The flow-control type chooses whether the source request, the destination request, both or neither must be present. Each side has its own access width and its own address-increment enable. A 12-bit element count in the control word counts down with every element written. When the count reaches zero, the block pulses a completion strobe for the descriptor fetcher. If the control word asks for it, it also pulses a terminal-count strobe for the interrupt logic. It then drops its own enable unless the fetcher reports that another descriptor is linked.

Top module: `dma_chan_engine`

## Requirements
- R1: An element starts only while configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0. Setting halt stops the channel after the element in progress and keeps the remaining count. Clearing halt resumes the transfer.
- R2: The flow type is configuration bits [13:11]. Type 0 needs no request. Type 1 needs the destination request. Type 2 needs the source request. Type 3 needs both requests. Types 4 to 7 never start an element.
- R3: The source peripheral index is configuration bits [5:1] and the destination index is bits [10:6]. Each index selects one bit of the OR of the single and burst request vectors.
- R4: The element count is control bits [11:0]. It drops by one in the cycle after each destination write is accepted. A count of zero starts nothing and leaves the enable bit set.
- R5: `mem_size_o` carries a width code: 0 for a byte, 1 for a halfword, 2 for a word. Codes above 2 are treated as a word. Reads use control bits [20:18] and writes use control bits [23:21]. The write data equals the word returned by the read before it.
- R6: When control bit 26 is set, the source address advances by the source width after each element. When control bit 27 is set, the destination address advances by the destination width. With a bit clear, that address stays unchanged.
- R7: After the write of the last element is accepted, `done_o` pulses for one cycle. In that same cycle the count reads zero. Enable is cleared unless `link_i` is high, in which case it stays set.
- R8: `tc_o` pulses together with `done_o` only when control bit 31 is set.
- R9: Each element is one read and then one write, with at most one access pending. The request, address, direction, size and write data stay fixed until `mem_ready_i` is high.
- R10: `reg_sel_i` selects source (0), destination (1), control (2) or configuration (3). A write on `reg_we_i` shows on the matching output from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select for the write |
| reg_wdata_i | input | 32 | Register write data |
| link_i | input | 1 | A further descriptor is linked |
| dreq_single_i | input | REQ_LINES | Single-transfer peripheral requests |
| dreq_burst_i | input | REQ_LINES | Burst peripheral requests, ORed with single |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| ctrl_o | output | 32 | Control word with remaining count |
| cfg_o | output | 32 | Configuration word |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Access byte address |
| mem_size_o | output | 3 | Access width code |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with ready |
| done_o | output | 1 | Last element written |
| tc_o | output | 1 | Terminal-count interrupt strobe |

## Verification
The assertions watch, on every cycle, that a pending access holds its address, direction and size, and that each write follows an accepted read. They also check that no element starts while disabled, halted, at zero count or with an unsupported flow type. Further checks are that each accepted write lowers the count by exactly one, and that the completion strobes line up with a zero count. Only the bench scenarios can show some of the behaviour. These are the request-line gating per flow type, the final address offsets for mixed widths and increment settings, and the data passing from read to write. They also cover enable handling with and without a link, and a halt and resume in the middle of a run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CFG  = 2'd3;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_SIDX_LSB  = 1;
  localparam int CFG_DIDX_LSB  = 6;
  localparam int CFG_FLOW_LSB  = 11;
  localparam int CFG_HALT_BIT  = 18;

  localparam int CTL_SCODE_LSB = 18;
  localparam int CTL_DCODE_LSB = 21;
  localparam int CTL_SINC_BIT  = 26;
  localparam int CTL_DINC_BIT  = 27;
  localparam int CTL_TC_BIT    = 31;

  function automatic logic [2:0] clamp_code(input logic [2:0] code,
                                            input logic [2:0] max_code);
    return (code > max_code) ? max_code : code;
  endfunction

endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int REQ_LINES = 32
) (
  input  logic [REQ_LINES-1:0] single_i,
  input  logic [REQ_LINES-1:0] burst_i,
  input  logic [4:0]           src_idx_i,
  input  logic [4:0]           dst_idx_i,
  input  logic [2:0]           flow_i,
  output logic                 permit_o
);

  logic [REQ_LINES-1:0] req_vec;
  logic                 src_hit;
  logic                 dst_hit;

  assign req_vec = single_i | burst_i;

  always_comb begin
    src_hit = 1'b0;
    dst_hit = 1'b0;
    for (int i = 0; i < REQ_LINES; i++) begin
      if (src_idx_i == 5'(i)) src_hit = req_vec[i];
      if (dst_idx_i == 5'(i)) dst_hit = req_vec[i];
    end
  end

  always_comb begin
    case (flow_i)
      3'd0:    permit_o = 1'b1;
      3'd1:    permit_o = dst_hit;
      3'd2:    permit_o = src_hit;
      3'd3:    permit_o = src_hit & dst_hit;
      default: permit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = REG_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    code_i,
  input  logic          inc_i,
  output logic [AW-1:0] next_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] step;

  assign step   = ONE << code_i;
  assign next_o = inc_i ? (addr_i + step) : addr_i;

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [REG_W-1:0]  src_addr_i,
  input  logic [REG_W-1:0]  dst_addr_i,
  input  logic [2:0]        src_code_i,
  input  logic [2:0]        dst_code_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic [2:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              el_done_o
);

  xfer_state_e       state_q, state_d;
  logic [REG_W-1:0]  sa_q, da_q;
  logic [2:0]        sc_q, dc_q;
  logic [DATA_W-1:0] data_q;
  logic              load_en;
  logic              cap_en;

  assign load_en = (state_q == XS_IDLE) && go_i;
  assign cap_en  = (state_q == XS_READ) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:  if (go_i)        state_d = XS_READ;
      XS_READ:  if (mem_ready_i) state_d = XS_WRITE;
      XS_WRITE: if (mem_ready_i) state_d = XS_IDLE;
      default:                   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '0;
      da_q <= '0;
      sc_q <= '0;
      dc_q <= '0;
    end else if (load_en) begin
      sa_q <= src_addr_i;
      da_q <= dst_addr_i;
      sc_q <= src_code_i;
      dc_q <= dst_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (state_q != XS_IDLE);
  assign mem_we_o    = (state_q == XS_WRITE);
  assign mem_addr_o  = mem_we_o ? da_q : sa_q;
  assign mem_size_o  = mem_we_o ? dc_q : sc_q;
  assign mem_wdata_o = data_q;
  assign el_done_o   = (state_q == XS_WRITE) && mem_ready_i;

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_size_o) && $stable(mem_wdata_o))); // R9

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ready_i)); // R9

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REQ_LINES = 32,
  parameter int CNT_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  input  logic                 link_i,
  input  logic [REQ_LINES-1:0] dreq_single_i,
  input  logic [REQ_LINES-1:0] dreq_burst_i,
  output logic [REG_W-1:0]     src_addr_o,
  output logic [REG_W-1:0]     dst_addr_o,
  output logic [REG_W-1:0]     ctrl_o,
  output logic [REG_W-1:0]     cfg_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [REG_W-1:0]     mem_addr_o,
  output logic [2:0]           mem_size_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic                 mem_ready_i,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 done_o,
  output logic                 tc_o
);

  localparam logic [2:0]       MAX_WCODE = 3'($clog2(DATA_W / 8));
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [REG_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [REG_W-1:0] ctrl_q, ctrl_d, cfg_q, cfg_d;
  logic             src_en, dst_en, ctrl_en, cfg_en;
  logic             done_q, done_d, tc_q, tc_d;

  logic [CNT_W-1:0] count;
  logic             active;
  logic             permit;
  logic             go;
  logic             el_done;
  logic             last;
  logic [2:0]       scode, dcode;
  logic [REG_W-1:0] src_step, dst_step;
  logic             wr_src, wr_dst, wr_ctrl, wr_cfg;

  assign count  = ctrl_q[CNT_W-1:0];
  assign active = cfg_q[CFG_EN_BIT] & ~cfg_q[CFG_HALT_BIT];
  assign last   = (count == CNT_ONE);
  assign scode  = clamp_code(ctrl_q[CTL_SCODE_LSB +: 3], MAX_WCODE);
  assign dcode  = clamp_code(ctrl_q[CTL_DCODE_LSB +: 3], MAX_WCODE);
  assign go     = active && (count != '0) && permit;

  assign wr_src  = reg_we_i && (reg_sel_i == SEL_SRC);
  assign wr_dst  = reg_we_i && (reg_sel_i == SEL_DST);
  assign wr_ctrl = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign wr_cfg  = reg_we_i && (reg_sel_i == SEL_CFG);

  dma_req_gate #(
    .REQ_LINES (REQ_LINES)
  ) u_gate (
    .single_i  (dreq_single_i),
    .burst_i   (dreq_burst_i),
    .src_idx_i (cfg_q[CFG_SIDX_LSB +: 5]),
    .dst_idx_i (cfg_q[CFG_DIDX_LSB +: 5]),
    .flow_i    (cfg_q[CFG_FLOW_LSB +: 3]),
    .permit_o  (permit)
  );

  dma_addr_step #(
    .AW (REG_W)
  ) u_src_step (
    .addr_i (src_q),
    .code_i (scode),
    .inc_i  (ctrl_q[CTL_SINC_BIT]),
    .next_o (src_step)
  );

  dma_addr_step #(
    .AW (REG_W)
  ) u_dst_step (
    .addr_i (dst_q),
    .code_i (dcode),
    .inc_i  (ctrl_q[CTL_DINC_BIT]),
    .next_o (dst_step)
  );

  dma_xfer_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .src_addr_i  (src_q),
    .dst_addr_i  (dst_q),
    .src_code_i  (scode),
    .dst_code_i  (dcode),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_wdata_o (mem_wdata_o),
    .el_done_o   (el_done)
  );

  // Register next state: the engine update first, a register write overrides it.
  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    ctrl_d = ctrl_q;
    cfg_d  = cfg_q;
    if (el_done) begin
      src_d                = src_step;
      dst_d                = dst_step;
      ctrl_d[CNT_W-1:0]    = count - CNT_ONE;
      if (last && !link_i) cfg_d[CFG_EN_BIT] = 1'b0;
    end
    if (wr_src)  src_d  = reg_wdata_i;
    if (wr_dst)  dst_d  = reg_wdata_i;
    if (wr_ctrl) ctrl_d = reg_wdata_i;
    if (wr_cfg)  cfg_d  = reg_wdata_i;
  end

  assign src_en  = el_done | wr_src;
  assign dst_en  = el_done | wr_dst;
  assign ctrl_en = el_done | wr_ctrl;
  assign cfg_en  = el_done | wr_cfg;

  assign done_d = el_done && last;
  assign tc_d   = el_done && last && ctrl_q[CTL_TC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (dst_en) begin
      dst_q <= dst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      tc_q   <= tc_d;
    end
  end

  assign src_addr_o = src_q;
  assign dst_addr_o = dst_q;
  assign ctrl_o     = ctrl_q;
  assign cfg_o      = cfg_q;
  assign done_o     = done_q;
  assign tc_o       = tc_q;

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> $past(cfg_q[CFG_EN_BIT] && !cfg_q[CFG_HALT_BIT])); // R1

  AST_FLOW_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> ($past(cfg_q[CFG_FLOW_LSB +: 3]) < 3'd4)); // R2

  AST_NONZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> ($past(ctrl_q[CNT_W-1:0]) != '0)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ready_i && !wr_ctrl) |=>
      (ctrl_q[CNT_W-1:0] == $past(ctrl_q[CNT_W-1:0]) - CNT_ONE)); // R4

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(wr_ctrl)) |-> (ctrl_q[CNT_W-1:0] == '0)); // R7

  AST_TC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> done_o); // R8

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 13;
  localparam logic [31:0] SRC_BASE = 32'h0000_1000;
  localparam logic [31:0] DST_BASE = 32'h0000_2000;
  localparam logic [31:0] RD_KEY   = 32'h5a5a_0000;

  typedef struct packed {
    logic [63:0] tag;
    logic [31:0] cfg;
    logic [31:0] ctrl;
    logic        link;
    logic [31:0] sreq;
    logic [31:0] breq;
    logic [11:0] elems;
    logic [31:0] sd;
    logic [31:0] dd;
    logic        en;
    logic [3:0]  tc;
  } vec_t;

  function automatic logic [31:0] mk_cfg(input logic en, input logic halt,
      input logic [2:0] flow, input logic [4:0] didx, input logic [4:0] sidx);
    return {13'd0, halt, 4'd0, flow, didx, sidx, en};
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic ti, input logic di,
      input logic si, input logic [2:0] dc, input logic [2:0] sc, input logic [11:0] n);
    return {ti, 3'd0, di, si, 2'd0, dc, sc, 6'd0, n};
  endfunction

  function automatic logic [2:0] clampw(input logic [2:0] c);
    return (c > 3'd2) ? 3'd2 : c;
  endfunction

  localparam vec_t VECS [NVEC] = '{
    '{"R4 R6", mk_cfg(1,0,0,0,0), mk_ctrl(1,1,1,2,2,4), 1'b0, 32'h0, 32'h0, 12'd4, 32'd16, 32'd16, 1'b0, 4'd1},
    '{"R5 R6", mk_cfg(1,0,0,0,0), mk_ctrl(1,0,1,1,0,3), 1'b0, 32'h0, 32'h0, 12'd3, 32'd3, 32'd0, 1'b0, 4'd1},
    '{"R2 R3", mk_cfg(1,0,1,5,0), mk_ctrl(1,1,1,2,2,2), 1'b0, 32'h20, 32'h0, 12'd2, 32'd8, 32'd8, 1'b0, 4'd1},
    '{"R3", mk_cfg(1,0,1,5,0), mk_ctrl(1,1,1,2,2,2), 1'b0, 32'h10, 32'h0, 12'd0, 32'd0, 32'd0, 1'b1, 4'd0},
    '{"R2 R8", mk_cfg(1,0,2,0,7), mk_ctrl(0,1,1,2,2,2), 1'b0, 32'h0, 32'h80, 12'd2, 32'd8, 32'd8, 1'b0, 4'd0},
    '{"R2", mk_cfg(1,0,3,9,3), mk_ctrl(1,1,1,2,2,2), 1'b0, 32'h0, 32'h8, 12'd0, 32'd0, 32'd0, 1'b1, 4'd0},
    '{"R3 R5", mk_cfg(1,0,3,9,3), mk_ctrl(1,1,0,0,2,3), 1'b0, 32'h200, 32'h8, 12'd3, 32'd0, 32'd3, 1'b0, 4'd1},
    '{"R1", mk_cfg(1,1,0,0,0), mk_ctrl(1,1,1,2,2,2), 1'b0, 32'h0, 32'h0, 12'd0, 32'd0, 32'd0, 1'b1, 4'd0},
    '{"R2", mk_cfg(1,0,5,0,0), mk_ctrl(1,1,1,2,2,2), 1'b0, 32'hffff_ffff, 32'h0, 12'd0, 32'd0, 32'd0, 1'b1, 4'd0},
    '{"R4", mk_cfg(1,0,0,0,0), mk_ctrl(1,1,1,2,2,0), 1'b0, 32'h0, 32'h0, 12'd0, 32'd0, 32'd0, 1'b1, 4'd0},
    '{"R7", mk_cfg(1,0,0,0,0), mk_ctrl(1,1,1,2,2,2), 1'b1, 32'h0, 32'h0, 12'd2, 32'd8, 32'd8, 1'b1, 4'd1},
    '{"R1", mk_cfg(0,0,0,0,0), mk_ctrl(1,1,1,2,2,2), 1'b0, 32'h0, 32'h0, 12'd0, 32'd0, 32'd0, 1'b0, 4'd0},
    '{"R5 R6", mk_cfg(1,0,0,0,0), mk_ctrl(1,1,1,3,5,2), 1'b0, 32'h0, 32'h0, 12'd2, 32'd8, 32'd8, 1'b0, 4'd1}
  };

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        link;
  logic [31:0] sreq, breq;
  logic [31:0] src_addr, dst_addr, ctrl, cfg;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [2:0]  mem_size;
  logic [31:0] mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic        done, tc;

  int          n_checks;
  int          n_fail;
  int          rd_cnt, wr_cnt, done_cnt, tc_cnt;
  logic [31:0] exp_data;
  logic [31:0] cur_ctrl;
  bit          finished;

  dma_chan_engine u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we_i      (reg_we),
    .reg_sel_i     (reg_sel),
    .reg_wdata_i   (reg_wdata),
    .link_i        (link),
    .dreq_single_i (sreq),
    .dreq_burst_i  (breq),
    .src_addr_o    (src_addr),
    .dst_addr_o    (dst_addr),
    .ctrl_o        (ctrl),
    .cfg_o         (cfg),
    .mem_req_o     (mem_req),
    .mem_we_o      (mem_we),
    .mem_addr_o    (mem_addr),
    .mem_size_o    (mem_size),
    .mem_wdata_o   (mem_wdata),
    .mem_ready_i   (mem_ready),
    .mem_rdata_i   (mem_rdata),
    .done_o        (done),
    .tc_o          (tc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mem_rdata = ~mem_addr ^ RD_KEY;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder and monitor: a new access is acknowledged one cycle later.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
    end else if (mem_req && !mem_ready) begin
      mem_ready <= 1'b1;
      if (!mem_we) begin
        rd_cnt++;
        exp_data = mem_rdata;
        check(mem_size == clampw(cur_ctrl[20:18]), "R5", "read size",
              {29'd0, mem_size}, {29'd0, clampw(cur_ctrl[20:18])});
      end else begin
        wr_cnt++;
        check(mem_wdata == exp_data, "R5", "write data", mem_wdata, exp_data);
        check(mem_size == clampw(cur_ctrl[23:21]), "R5", "write size",
              {29'd0, mem_size}, {29'd0, clampw(cur_ctrl[23:21])});
      end
    end else begin
      mem_ready <= 1'b0;
    end
    if (rst_n && done) done_cnt++;
    if (rst_n && tc)   tc_cnt++;
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = val;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string tg;
    tg = $sformatf("%s vec%0d", v.tag, idx);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; tc_cnt = 0;
    cur_ctrl = v.ctrl;
    sreq = v.sreq;
    breq = v.breq;
    link = v.link;
    wr_reg(2'd0, SRC_BASE);
    wr_reg(2'd1, DST_BASE);
    wr_reg(2'd2, v.ctrl);
    wr_reg(2'd3, v.cfg);
    wait_cyc(150);
    check(wr_cnt == int'(v.elems), tg, "elements written", 32'(wr_cnt), {20'd0, v.elems});
    check(src_addr == SRC_BASE + v.sd, tg, "src addr", src_addr, SRC_BASE + v.sd);
    check(dst_addr == DST_BASE + v.dd, tg, "dst addr", dst_addr, DST_BASE + v.dd);
    check(ctrl[11:0] == v.ctrl[11:0] - v.elems, tg, "count left",
          {20'd0, ctrl[11:0]}, {20'd0, v.ctrl[11:0] - v.elems});
    check(cfg[0] == v.en, tg, "enable after", {31'd0, cfg[0]}, {31'd0, v.en});
    check(done_cnt == ((v.elems != 0) ? 1 : 0), tg, "done pulses (R7)",
          32'(done_cnt), (v.elems != 0) ? 32'd1 : 32'd0);
    check(tc_cnt == int'(v.tc), tg, "tc pulses (R8)", 32'(tc_cnt), {28'd0, v.tc});
    wr_reg(2'd3, 32'h0);
    sreq = '0;
    breq = '0;
    link = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; finished = 1'b0;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; tc_cnt = 0;
    exp_data = '0; cur_ctrl = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    link = 1'b0; sreq = '0; breq = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // Reset state
    check(mem_req == 1'b0, "R9", "reset mem_req", {31'd0, mem_req}, 32'd0);
    check(cfg == 32'h0, "R1", "reset cfg", cfg, 32'h0);
    check(ctrl == 32'h0, "R4", "reset ctrl", ctrl, 32'h0);
    check(done == 1'b0 && tc == 1'b0, "R7", "reset strobes", {30'd0, done, tc}, 32'd0);

    // Register write port readback
    wr_reg(2'd0, 32'hcafe_0010);
    check(src_addr == 32'hcafe_0010, "R10", "src readback", src_addr, 32'hcafe_0010);
    wr_reg(2'd1, 32'h0bad_0020);
    check(dst_addr == 32'h0bad_0020, "R10", "dst readback", dst_addr, 32'h0bad_0020);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // Halt in the middle of a run, then resume
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; tc_cnt = 0;
    cur_ctrl = mk_ctrl(0, 1, 1, 2, 2, 10);
    wr_reg(2'd0, SRC_BASE);
    wr_reg(2'd1, DST_BASE);
    wr_reg(2'd2, cur_ctrl);
    wr_reg(2'd3, mk_cfg(1, 0, 0, 0, 0));
    wait_cyc(12);
    wr_reg(2'd3, mk_cfg(1, 1, 0, 0, 0));
    wait_cyc(20);
    begin
      logic [11:0] held;
      held = ctrl[11:0];
      check(held != 0 && held < 12'd10, "R1", "count held at halt", {20'd0, held}, 32'd5);
      check(wr_cnt == 10 - int'(held), "R1", "writes vs count", 32'(wr_cnt), 32'(10 - int'(held)));
      wait_cyc(30);
      check(ctrl[11:0] == held, "R1", "count stable while halted", {20'd0, ctrl[11:0]}, {20'd0, held});
      check(mem_req == 1'b0, "R1", "no access while halted", {31'd0, mem_req}, 32'd0);
    end
    wr_reg(2'd3, mk_cfg(1, 0, 0, 0, 0));
    wait_cyc(80);
    check(ctrl[11:0] == 12'd0, "R1", "resume finishes", {20'd0, ctrl[11:0]}, 32'd0);
    check(wr_cnt == 10, "R1", "total writes after resume", 32'(wr_cnt), 32'd10);
    check(cfg[0] == 1'b0, "R7", "enable cleared after resume", {31'd0, cfg[0]}, 32'd0);
    check(dst_addr == DST_BASE + 32'd40, "R6", "dst after resume", dst_addr, DST_BASE + 32'd40);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule